// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides, for every frame a CAN receiver has finished collecting, whether the frame should be kept. It compares the frame's 32-bit identifier word against a bank of programmable mask/ID pairs, four by default. Each pair has its own enable bit. A set mask bit makes the matching identifier bit significant, and a clear mask bit makes it a don't-care. The frame is kept when at least one enabled pair matches. When no pair is enabled, the bank keeps every frame.

The receiver presents the identifier word together with a one-cycle valid strobe. One clock later the bank produces a registered decision-valid strobe, and alongside it a one-cycle accept pulse. Software programs the bank through a simple register port with a write strobe, an address, write data and combinational read data.

A mask or ID register only takes a write while its own filter is disabled. It also refuses the write while the bank is busy comparing a frame, so a decision is never made against half-updated values. The enable register can be written at any time.

Top module: `can_id_filter_bank`

## Requirements
- R1: After reset, `accept`, `decision_valid` and `busy` are low, and every register reads back as zero.
- R2: `decision_valid` is high exactly in the cycle after each cycle with `frame_valid` high, and only then. `accept` is never high without `decision_valid`.
- R3: While the enable register is zero, every frame is accepted.
- R4: A filter matches when `((frame_id ^ id) & mask) == 0`. Identifier bits whose mask bit is 0 do not affect the result.
- R5: With one or more filters enabled, a frame is accepted if and only if at least one enabled filter matches. A disabled filter that matches has no effect.
- R6: A write to a filter's mask or ID register is ignored while that filter's enable bit is set. The old value is still read back.
- R7: `busy` is high in every cycle where `frame_valid` or `decision_valid` is high, and low otherwise. Mask/ID writes made while `busy` is high are ignored.
- R8: The enable register stores only write-data bits [NUM_FLT-1:0], with bit k enabling filter k. Its upper bits always read as zero.
- R9: The register addresses are:
  - address 0: the enable register;
  - address 1+2k: mask k;
  - address 2+2k: ID k.

  Reads of any other address return zero, and writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: `frame_id` holds a received identifier word |
| frame_id | input | ID_W | Identifier word of the received frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address, used for both write and read |
| reg_wdata | input | ID_W | Register write data |
| reg_rdata | output | ID_W | Read data for `reg_addr` (combinational) |
| accept | output | 1 | Keep-frame pulse, aligned with `decision_valid` |
| decision_valid | output | 1 | Decision strobe, one cycle after `frame_valid` |
| busy | output | 1 | Comparison in progress; mask/ID writes are refused |

## Verification
The identifier patterns are chosen so that each one distinguishes a particular kind of fault:
- All-zero, all-one and mixed identifiers with the bank fully open show whether the no-filter case really passes everything.
- Identifiers that differ from a programmed ID only in masked-out bits, only in a significant high bit, or only in a significant low bit separate a correct masked compare from an unmasked or inverted one.
- Identifiers that match exactly one of two enabled filters, or only a disabled filter, show whether the bank ORs over the enabled filters alone.

Register writes are placed in the strobe cycle, in the decision cycle and on locked filters, which exposes any missing write guard. A behavioural model predicts every output on every clock.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EN   = 2'd1,
      SEL_MASK = 2'd2,
      SEL_ID   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
   import can_flt_pkg::*;
#(
   parameter int NUM_FLT = 4,
   parameter int ID_W    = 32,
   parameter int ADDR_W  = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             busy_i,
   input  logic                             wr_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [ID_W-1:0]                  wdata_i,
   output logic [ID_W-1:0]                  rdata_o,
   output logic [NUM_FLT-1:0]               en_o,
   output logic [NUM_FLT-1:0][ID_W-1:0]     mask_o,
   output logic [NUM_FLT-1:0][ID_W-1:0]     id_o
);
   localparam int IW       = (NUM_FLT > 1) ? $clog2(NUM_FLT) : 1;
   localparam int LAST_REG = 2 * NUM_FLT;

   reg_sel_e                  sel;
   logic [IW-1:0]             idx;
   logic [ADDR_W-1:0]         a_off;
   logic [NUM_FLT-1:0]        en_q;
   logic [NUM_FLT-1:0][ID_W-1:0] mask_q;
   logic [NUM_FLT-1:0][ID_W-1:0] id_q;

   // address decode: 0 = enable, odd = mask, even non-zero = id
   always_comb begin
      sel   = SEL_NONE;
      idx   = '0;
      a_off = addr_i - ADDR_W'(1);
      if (addr_i == '0) begin
         sel = SEL_EN;
      end else if (int'(addr_i) <= LAST_REG) begin
         idx = IW'(a_off >> 1);
         sel = a_off[0] ? SEL_ID : SEL_MASK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        en_q <= '0;
      else if (wr_i && sel == SEL_EN)    en_q <= wdata_i[NUM_FLT-1:0];
   end

   for (genvar k = 0; k < NUM_FLT; k++) begin : g_flt
      logic open_k;
      assign open_k = wr_i && !busy_i && !en_q[k] && (idx == IW'(k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[k] <= '0;
            id_q[k]   <= '0;
         end else begin
            if (open_k && sel == SEL_MASK) mask_q[k] <= wdata_i;
            if (open_k && sel == SEL_ID)   id_q[k]   <= wdata_i;
         end
      end

      a_r6_locked_filter_holds: assert property (@(posedge clk) disable iff (!rst_n)
         en_q[k] |=> ($stable(mask_q[k]) && $stable(id_q[k])));
   end

   always_comb begin
      unique case (sel)
         SEL_EN:   rdata_o = ID_W'(en_q);
         SEL_MASK: rdata_o = mask_q[idx];
         SEL_ID:   rdata_o = id_q[idx];
         default:  rdata_o = '0;
      endcase
   end

   assign en_o   = en_q;
   assign mask_o = mask_q;
   assign id_o   = id_q;

   // R7: no mask/id change across a busy cycle
   a_r7_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> ($stable(mask_q) && $stable(id_q)));
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match #(
   parameter int NUM_FLT = 4,
   parameter int ID_W    = 32
) (
   input  logic [ID_W-1:0]               frame_id_i,
   input  logic [NUM_FLT-1:0]            en_i,
   input  logic [NUM_FLT-1:0][ID_W-1:0]  mask_i,
   input  logic [NUM_FLT-1:0][ID_W-1:0]  id_i,
   output logic                          pass_o
);
   logic [NUM_FLT-1:0] hit;

   for (genvar k = 0; k < NUM_FLT; k++) begin : g_cmp
      assign hit[k] = (((frame_id_i ^ id_i[k]) & mask_i[k]) == '0);
   end

   assign pass_o = (en_i == '0) || ((en_i & hit) != '0);
endmodule

// File: rtl/can_flt_decide.sv
module can_flt_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_valid_i,
   input  logic pass_i,
   output logic accept_o,
   output logic valid_o,
   output logic busy_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         accept_o <= 1'b0;
      end else begin
         valid_o  <= frame_valid_i;
         accept_o <= frame_valid_i && pass_i;
      end
   end

   assign busy_o = frame_valid_i || valid_o;

   a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_i |=> valid_o);
   a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid_i |=> !valid_o);
   a_r2_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> valid_o);
endmodule

// File: rtl/can_id_filter_bank.sv
module can_id_filter_bank #(
   parameter int NUM_FLT = 4,
   parameter int ID_W    = 32,
   parameter int ADDR_W  = $clog2(2 * NUM_FLT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid,
   input  logic [ID_W-1:0]   frame_id,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [ID_W-1:0]   reg_wdata,
   output logic [ID_W-1:0]   reg_rdata,
   output logic              accept,
   output logic              decision_valid,
   output logic              busy
);
   if (NUM_FLT < 1 || NUM_FLT > ID_W)
      $error("NUM_FLT must be between 1 and ID_W");
   if ((1 << ADDR_W) < 2 * NUM_FLT + 1)
      $error("ADDR_W too narrow for the register map");

   logic [NUM_FLT-1:0]           en;
   logic [NUM_FLT-1:0][ID_W-1:0] mask;
   logic [NUM_FLT-1:0][ID_W-1:0] idv;
   logic                         pass;

   can_flt_regs #(.NUM_FLT(NUM_FLT), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_i  (busy),
      .wr_i    (reg_wr),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .en_o    (en),
      .mask_o  (mask),
      .id_o    (idv)
   );

   can_flt_match #(.NUM_FLT(NUM_FLT), .ID_W(ID_W)) u_match (
      .frame_id_i (frame_id),
      .en_i       (en),
      .mask_i     (mask),
      .id_i       (idv),
      .pass_o     (pass)
   );

   can_flt_decide u_decide (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_valid_i (frame_valid),
      .pass_i        (pass),
      .accept_o      (accept),
      .valid_o       (decision_valid),
      .busy_o        (busy)
   );

   a_r3_open_bank_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && en == '0) |=> accept);
endmodule

// File: tb/can_id_filter_bank_bench.sv
`timescale 1ns/1ps
module can_id_filter_bank_bench;
   localparam int NF = 4;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_valid = 1'b0;
   logic [31:0] frame_id = '0;
   logic reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic accept, decision_valid, busy;

   int checks = 0;
   int errors = 0;
   string phase = "R1";

   always #2 clk = ~clk;

   can_id_filter_bank u_can_id_filter_bank (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_id(frame_id),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .accept(accept), .decision_valid(decision_valid),
      .busy(busy));

   // behavioural reference state
   logic [31:0] m_mask [NF];
   logic [31:0] m_id   [NF];
   logic [NF-1:0] m_en;
   logic e_valid, e_acc;

   function automatic bit model_pass(logic [31:0] fid);
      if (m_en == '0) return 1'b1;
      for (int k = 0; k < NF; k++)
         if (m_en[k] && (((fid ^ m_id[k]) & m_mask[k]) == 32'd0)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] model_read(int a);
      if (a == 0) return {28'd0, m_en};
      if (a >= 1 && a <= 2 * NF) return ((a - 1) % 2 == 0) ? m_mask[(a - 1) / 2] : m_id[(a - 1) / 2];
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NF; k++) begin m_mask[k] = '0; m_id[k] = '0; end
         m_en = '0; e_valid = 1'b0; e_acc = 1'b0;
      end else begin
         bit bsy, nacc;
         int a;
         bsy  = frame_valid || e_valid;
         nacc = frame_valid && model_pass(frame_id);
         a    = int'(reg_addr);
         if (reg_wr) begin
            if (a == 0) m_en = reg_wdata[NF-1:0];
            else if (a <= 2 * NF && !m_en[(a - 1) / 2] && !bsy) begin
               if ((a - 1) % 2 == 0) m_mask[(a - 1) / 2] = reg_wdata;
               else                  m_id[(a - 1) / 2]   = reg_wdata;
            end
         end
         e_valid = frame_valid;
         e_acc   = nacc;
      end
   end

   task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(decision_valid === e_valid, "decision_valid", 32'(decision_valid), 32'(e_valid));
         chk(accept === e_acc, "accept", 32'(accept), 32'(e_acc));
         chk(busy === (frame_valid || e_valid), "busy", 32'(busy), 32'(frame_valid || e_valid));
         chk(reg_rdata === model_read(int'(reg_addr)), "reg_rdata",
             reg_rdata, model_read(int'(reg_addr)));
      end
   end

   task automatic step(bit fv, logic [31:0] fid, bit we, int a, logic [31:0] wd);
      @(posedge clk); #1;
      frame_valid = fv; frame_id = fid; reg_wr = we; reg_addr = AW'(a); reg_wdata = wd;
   endtask
   task automatic idle(int a); step(0, 0, 0, a, 0); endtask
   task automatic wr(int a, logic [31:0] d); step(0, 0, 1, a, d); idle(a); endtask
   task automatic frame(logic [31:0] fid); step(1, fid, 0, 0, 0); idle(0); endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      phase = "R1";
      chk(accept === 1'b0 && decision_valid === 1'b0, "reset outputs",
          {30'd0, accept, decision_valid}, 32'd0);
      rst_n = 1'b1;
      for (int a = 0; a <= 2 * NF; a++) idle(a);

      phase = "R3";
      frame(32'h0000_0000); frame(32'hFFFF_FFFF);
      step(1, 32'h1234_5678, 0, 0, 0); step(1, 32'h8000_0001, 0, 0, 0); idle(0);

      phase = "R8";
      wr(0, 32'hFFFF_FFF0); wr(0, 32'h0000_005A); wr(0, 32'h0);

      phase = "R9";
      for (int a = 2 * NF + 1; a < 16; a++) wr(a, 32'hDEAD_BEEF);
      for (int a = 0; a <= 2 * NF; a++) idle(a);

      phase = "R4";
      wr(1, 32'hFFE0_0000); wr(2, 32'h2460_0000); wr(0, 32'h1);
      frame(32'h2460_0000); frame(32'h246F_FFFF); frame(32'h2480_0000); frame(32'hA460_0000);

      phase = "R6";
      wr(1, 32'h0000_0000); wr(2, 32'h0000_0001); idle(1); idle(2);
      frame(32'h0000_0000);

      phase = "R5";
      wr(5, 32'hFFFF_FFFF); wr(6, 32'h0000_0123); wr(3, 32'h0); wr(0, 32'h5);
      frame(32'h0000_0123); frame(32'h2460_0001); frame(32'h0000_0124);
      wr(0, 32'h4); frame(32'h2460_0000); frame(32'h0000_0123);
      wr(0, 32'h2); frame(32'h5555_AAAA);

      phase = "R7";
      wr(0, 32'h0);
      step(1, 32'h1, 1, 7, 32'h0000_FFFF); idle(7);
      step(1, 32'h2, 0, 0, 0); step(0, 0, 1, 8, 32'h0000_0777); idle(8);
      wr(8, 32'h0000_0777); idle(8);

      phase = "R2";
      begin
         logic [31:0] lcg = 32'h1357_9BDF;
         wr(0, 32'h5);
         for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(i % 3 != 2, (i % 4 == 0) ? 32'h2460_0000 ^ (lcg & 32'h000F_FFFF) : lcg,
                 0, i % 9, 0);
         end
         idle(0); idle(0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule